// File: doc/BRIEF.md
# Hot-Swap Two-Wire Bus Join Controller

This block decides when a plug-in card's two-wire bus (data and clock) may be joined to a backplane bus that is already carrying traffic. It watches synchronised copies of the four line levels, an enable input and a supply-good flag. It drives four outputs: a join strobe for the pass logic, a rise-accelerator enable, a precharge enable and a ready flag. The analog precharge, the pass devices and the boost currents sit outside this block.

After supply-good is asserted, the enable input must first stay high through a rising-only filter window. The controller then waits for a transaction on the backplane to finish. A finished transaction is either a STOP condition (data rising while clock is high in both the previous and current sample) or an idle window in which both backplane lines stay high for a set number of cycles. At that point it checks that both card lines are high. If they are, it joins the buses. If not, it waits for a fresh STOP or idle window. Dropping enable or supply-good breaks the join at once, and the full sequence runs again afterwards.

Top module: `hsw_join_ctrl`

## Requirements
- R1: While supply-good is low, the block is in lockout: precharge enable is 1, join, accelerator enable and ready are 0, and no line activity changes this.
- R2: After supply-good and enable are both high, no join happens until enable has been high for EN_DELAY_CYCLES consecutive cycles. A fresh lockout restarts this window.
- R3: A backplane STOP (data 0 to 1 while clock is 1 in both samples) ends the wait. With both card lines high, ready rises within 6 cycles of the data rise at the input pins.
- R4: Both backplane lines held high for IDLE_CYCLES cycles also end the wait. Any low level on either backplane line restarts the count, so traffic with short clock-high phases never causes a join.
- R5: If either card line is low when the wait ends, the block stays disconnected. A later rise of the card lines alone does not join; a new STOP or idle window is needed.
- R6: While joined, the join, accelerator enable and ready outputs are all 1 and precharge enable is 0. Ready is never 1 without the join.
- R7: Enable going low drives join, accelerator enable, ready and precharge enable to 0 within 3 cycles at the pins.
- R8: When enable returns high, the enable filter window and a new end-of-transaction wait with the card check must both complete before the join closes again.
- R9: Supply-good going low returns the block to lockout from any state within 3 cycles at the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Supply-good flag, high once undervoltage lockout has released |
| enable_i | input | 1 | Enable request, 1 = allow the join |
| bp_sda_i | input | 1 | Backplane data line level |
| bp_scl_i | input | 1 | Backplane clock line level |
| card_sda_i | input | 1 | Card data line level |
| card_scl_i | input | 1 | Card clock line level |
| join_o | output | 1 | Join strobe to the bidirectional pass logic |
| accel_en_o | output | 1 | Rise-time accelerator enable |
| precharge_en_o | output | 1 | Line precharge enable |
| ready_o | output | 1 | Ready flag, 1 while the buses are joined |

## Verification
The bench builds the block with IDLE_CYCLES = 40 and EN_DELAY_CYCLES = 16. This keeps the filter window and the idle window short enough to cross many times in one run. They stay far enough apart that a STOP-driven join (a few cycles) cannot be confused with an idle-driven one. Random clock and data traffic with clock-high phases of at most 6 cycles checks that no join happens early. Directed STOPs with the card held low, disable/re-enable, and supply loss while joined cover the ordering rules.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef enum logic [2:0] {
    HS_LOCKOUT    = 3'd0,
    HS_EN_DELAY   = 3'd1,
    HS_WAIT_END   = 3'd2,
    HS_CHECK_CARD = 3'd3,
    HS_CONNECTED  = 3'd4
  } hsw_state_e;

  typedef struct packed {
    logic supply;
    logic enable;
    logic bp_sda;
    logic bp_scl;
    logic card_sda;
    logic card_scl;
  } hsw_lines_t;
endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsw_rise_filter.sv
module hsw_rise_filter #(
  parameter int HOLD_CYCLES = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic level_i,
  output logic filt_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (clear_i || !level_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != HOLD_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign filt_o = (cnt_q == HOLD_MAX);

  // R2: the filtered enable only rises after the raw level was high
  a_r2_filter_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_o) |-> $past(level_i) && !$past(clear_i));
  // R7: a low level removes the filtered enable on the next cycle
  a_r7_filter_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !level_i |=> !filt_o);
endmodule

// File: rtl/hsw_bus_end_detect.sv
module hsw_bus_end_detect #(
  parameter int IDLE_CYCLES = 9500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic stop_o,
  output logic idle_o
);
  localparam int IW = $clog2(IDLE_CYCLES + 1);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYCLES);

  logic          sda_prev_q, scl_prev_q;
  logic [IW-1:0] idle_q, idle_d;
  logic          idle_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b0;
      scl_prev_q <= 1'b0;
    end else begin
      sda_prev_q <= sda_i;
      scl_prev_q <= scl_i;
    end
  end

  assign stop_o = sda_i && !sda_prev_q && scl_i && scl_prev_q;

  always_comb begin
    idle_en = 1'b0;
    idle_d  = idle_q;
    if (restart_i || !sda_i || !scl_i) begin
      idle_en = 1'b1;
      idle_d  = '0;
    end else if (idle_q != IDLE_MAX) begin
      idle_en = 1'b1;
      idle_d  = idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idle_q <= '0;
    else if (idle_en) idle_q <= idle_d;
  end

  assign idle_o = (idle_q == IDLE_MAX);

  // R4: idle is only reached after both lines were high
  a_r4_idle_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_o) |-> $past(sda_i) && $past(scl_i) && !$past(restart_i));
  // R4: a low line clears the idle indication on the next cycle
  a_r4_low_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!sda_i || !scl_i) |=> !idle_o);
  // R3: a stop is only flagged with clock held high across two samples
  a_r3_stop_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> scl_i && $past(scl_i) && !$past(sda_i));
endmodule

// File: rtl/hsw_join_ctrl.sv
module hsw_join_ctrl
  import hsw_pkg::*;
#(
  parameter int IDLE_CYCLES     = 9500,
  parameter int EN_DELAY_CYCLES = 9500,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_i,
  input  logic enable_i,
  input  logic bp_sda_i,
  input  logic bp_scl_i,
  input  logic card_sda_i,
  input  logic card_scl_i,
  output logic join_o,
  output logic accel_en_o,
  output logic precharge_en_o,
  output logic ready_o
);
  localparam int NLINES = $bits(hsw_lines_t);

  hsw_lines_t raw_lines, sync_lines;
  hsw_state_e state_q, state_d;
  logic       en_filt, stop_evt, idle_evt, card_high, lockout;

  assign raw_lines = '{supply: supply_ok_i, enable: enable_i,
                       bp_sda: bp_sda_i, bp_scl: bp_scl_i,
                       card_sda: card_sda_i, card_scl: card_scl_i};

  hsw_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_lines), .q_o(sync_lines)
  );

  assign lockout = (state_q == HS_LOCKOUT);

  hsw_rise_filter #(.HOLD_CYCLES(EN_DELAY_CYCLES)) u_en_filter (
    .clk(clk), .rst_n(rst_n), .clear_i(lockout),
    .level_i(sync_lines.enable), .filt_o(en_filt)
  );

  hsw_bus_end_detect #(.IDLE_CYCLES(IDLE_CYCLES)) u_end_detect (
    .clk(clk), .rst_n(rst_n), .restart_i(state_q != HS_WAIT_END),
    .sda_i(sync_lines.bp_sda), .scl_i(sync_lines.bp_scl),
    .stop_o(stop_evt), .idle_o(idle_evt)
  );

  assign card_high = sync_lines.card_sda && sync_lines.card_scl;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_LOCKOUT:    state_d = HS_EN_DELAY;
      HS_EN_DELAY:   if (en_filt) state_d = HS_WAIT_END;
      HS_WAIT_END:   if (stop_evt || idle_evt) state_d = HS_CHECK_CARD;
      HS_CHECK_CARD: state_d = card_high ? HS_CONNECTED : HS_WAIT_END;
      HS_CONNECTED:  state_d = HS_CONNECTED;
      default:       state_d = HS_LOCKOUT;
    endcase
    if (!sync_lines.enable && state_q != HS_LOCKOUT) state_d = HS_EN_DELAY;
    if (!sync_lines.supply) state_d = HS_LOCKOUT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_LOCKOUT;
    else        state_q <= state_d;
  end

  assign join_o         = (state_q == HS_CONNECTED);
  assign accel_en_o     = join_o;
  assign ready_o        = join_o;
  assign precharge_en_o = lockout || (!join_o && sync_lines.enable);

  // R9: loss of supply forces lockout on the next cycle
  a_r9_supply_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_lines.supply |=> lockout && precharge_en_o && !ready_o);
  // R7: enable low while joined breaks the join on the next cycle
  a_r7_enable_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_lines.enable |=> !join_o && !accel_en_o && !ready_o);
  // R5: a join only closes after card lines were seen high
  a_r5_card_checked: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(join_o) |-> $past(card_high) && $past(state_q == HS_CHECK_CARD));
  // R2: joining needs the filtered enable and supply one cycle earlier
  a_r2_join_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(sync_lines.supply) && $past(sync_lines.enable));
  // R6: the checked state is only left toward a join or a new wait
  a_r6_check_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_CHECK_CARD) |=> state_q != HS_CHECK_CARD);
endmodule

// File: tb/tb_hsw_join_ctrl.sv
module tb_hsw_join_ctrl;
  localparam int IDLE_N = 40;
  localparam int DLY_N  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, enable = 1'b0;
  logic bp_sda = 1'b0, bp_scl = 1'b0, card_sda = 1'b0, card_scl = 1'b0;
  logic join_w, accel_w, pre_w, ready_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hsw_join_ctrl #(.IDLE_CYCLES(IDLE_N), .EN_DELAY_CYCLES(DLY_N)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .enable_i(enable),
    .bp_sda_i(bp_sda), .bp_scl_i(bp_scl), .card_sda_i(card_sda),
    .card_scl_i(card_scl), .join_o(join_w), .accel_en_o(accel_w),
    .precharge_en_o(pre_w), .ready_o(ready_w)
  );

  // expected {join, accel, precharge, ready}: 0 lockout, 1 enabled waiting,
  // 2 disabled, 3 joined
  function automatic logic [3:0] exp_out(int mode);
    case (mode)
      0: return 4'b0010;
      1: return 4'b0010;
      2: return 4'b0000;
      default: return 4'b1101;
    endcase
  endfunction

  function automatic bit is_stop(logic ps, logic pc, logic s, logic c);
    return s && !ps && c && pc;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_out(int mode, string req);
    logic [3:0] act;
    act = {join_w, accel_w, pre_w, ready_w};
    checks++;
    if (act !== exp_out(mode)) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp_out(mode), $time);
    end
  endtask

  // random clock/data traffic: data moves only while clock is low,
  // clock-high phases last at most 6 cycles, so neither STOP nor idle occurs
  task automatic traffic(int n, bit rand_card);
    logic ps, pc;
    for (int i = 0; i < n; i++) begin
      ps = bp_sda; pc = bp_scl;
      if (bp_scl) begin
        if ($urandom_range(0, 2) == 0 || i % 6 == 5) bp_scl = 1'b0;
      end else begin
        bp_sda = 1'($urandom_range(0, 1));
        if ($urandom_range(0, 1) == 1) bp_scl = 1'b1;
      end
      if (is_stop(ps, pc, bp_sda, bp_scl)) bp_sda = ps;
      if (rand_card) begin
        card_sda = 1'($urandom_range(0, 1));
        card_scl = 1'($urandom_range(0, 1));
      end
      cyc(1);
    end
  endtask

  task automatic send_stop();
    bp_scl = 1'b0; cyc(2);
    bp_sda = 1'b0; cyc(2);
    bp_scl = 1'b1; cyc(3);
    bp_sda = 1'b1; cyc(1);
  endtask

  initial begin
    int seed_tap;
    seed_tap = $urandom(32'd4177);
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    check_out(0, "R1 reset");

    // R1: activity under lockout is ignored
    enable = 1'b1; bp_sda = 1'b1; bp_scl = 1'b1; card_sda = 1'b1; card_scl = 1'b1;
    cyc(60); check_out(0, "R1 lockout idle");
    send_stop(); cyc(6); check_out(0, "R1 lockout stop");

    // R2/R4: supply release, filter then idle window, join after 62 cycles
    supply_ok = 1'b1;
    cyc(55); check_out(1, "R2 R4 before window");
    cyc(15); check_out(3, "R4 idle join");
    check_out(3, "R6 joined outputs");

    // R7: enable drop
    enable = 1'b0; cyc(4); check_out(2, "R7 enable drop");

    // R8/R3: re-enable under traffic, then STOP joins quickly
    enable = 1'b1;
    traffic(300, 1'b1);
    check_out(1, "R8 R4 traffic no join");
    card_sda = 1'b1; card_scl = 1'b1;
    traffic(10, 1'b0);
    check_out(1, "R8 card high alone");
    send_stop(); cyc(5);
    check_out(3, "R3 stop join");

    // R5: card low at the STOP, then card rises without a new event
    enable = 1'b0; cyc(4); check_out(2, "R7 second drop");
    enable = 1'b1; card_sda = 1'b0;
    traffic(40, 1'b0);
    send_stop(); cyc(6); check_out(1, "R5 card low at stop");
    traffic(8, 1'b0);
    card_sda = 1'b1;
    traffic(20, 1'b0); check_out(1, "R5 card rise alone");
    send_stop(); cyc(5); check_out(3, "R5 new stop joins");

    // R5 idle path: card clock low while backplane idle
    enable = 1'b0; cyc(4); enable = 1'b1; card_scl = 1'b0;
    cyc(150); check_out(1, "R5 idle with card low");
    card_scl = 1'b1; cyc(60); check_out(3, "R5 later idle joins");

    // R9: supply loss while joined, then full restart
    supply_ok = 1'b0; cyc(4); check_out(0, "R9 supply loss");
    supply_ok = 1'b1; cyc(30); check_out(1, "R9 R2 restart delay");
    cyc(40); check_out(3, "R9 rejoin");

    // random directed mix: random enable pulses never join within the filter
    for (int k = 0; k < 6; k++) begin
      int hold;
      hold = $urandom_range(2, DLY_N);
      enable = 1'b0; cyc(4);
      enable = 1'b1; cyc(hold);
      check_out(1, "R2 random short enable");
      cyc(IDLE_N + DLY_N + 10);
      check_out(3, "R8 random rejoin");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule